// File: doc/BRIEF.md
# Control Endpoint Request Handler

This block takes over the control requests that a device cannot answer by itself and hands them to an external master over a small byte-wide register port. When the USB-side engine delivers an 8-byte setup packet, the block stores it and raises a setup interrupt. The master then pulls the packet out one byte per read from a single auto-advancing register. At any time the master can refuse the request by writing a non-zero value to that same register, which stalls the endpoint until the next setup packet arrives.

For requests with a data phase, the block manages a 64-byte endpoint-0 buffer. The direction is bit 7 of setup byte 0, and the data-phase length is wLength, which is setup byte 6 (low) and byte 7 (high). In the device-to-host direction, the master fills the buffer byte by byte and commits a packet by writing its size to the count register. The size is clipped to 64 and to the wLength bytes still owed. The status stage completes on its own once a short packet, a zero-length packet or the last owed byte has gone out. In the host-to-device direction, the USB engine writes bytes into the buffer and marks the packet end. The master reads the count and the bytes, then releases the buffer by writing the count register.

The control state machine has these states: IDLE, IN_FILL (buffer free for the master), IN_BUSY (packet committed, waiting for the host), OUT_WAIT (waiting for a host packet), OUT_FULL (host packet ready for the master), DONE (one-cycle status completion) and STALLED. The transitions are:
- setup with wLength zero: any state to DONE.
- setup with bit 7 set: any state to IN_FILL.
- setup with bit 7 clear: any state to OUT_WAIT.
- count write: IN_FILL to IN_BUSY.
- host acknowledge: IN_BUSY to DONE on the last packet, otherwise back to IN_FILL.
- packet end: OUT_WAIT to OUT_FULL.
- count write: OUT_FULL to DONE on the last packet, otherwise back to OUT_WAIT.
- DONE to IDLE.
- stall write: any state to STALLED, with setup taking priority.

Top module: `ctl_ep_handler`

## Requirements
- R1: One cycle after `usb_setup_vld`, `irq_setup` is high. It stays high until the first read of the setup register (address 0x32).
- R2: Successive reads of address 0x32 return setup bytes 0 to 7 in order, one per read, where byte n is `usb_setup_pkt[8n+7:8n]`. Every read after the eighth returns 0x00. Read data appears on `reg_rdata` one cycle after the `reg_rd` strobe.
- R3: One cycle after a write of a non-zero value to address 0x32, `ep0_stall` is high, and `irq_buf` and `in_pkt_rdy` are low. A write of 0x00 has no effect.
- R4: A new setup packet clears the stall and moves the setup read pointer back to byte 0.
- R5: The direction is bit 7 of setup byte 0 (1 means device-to-host). wLength is byte 6 (low) and byte 7 (high). When wLength is zero, `status_ok` pulses for one cycle right after the setup, and no data phase starts.
- R6: In the device-to-host direction, `irq_buf` is high while the buffer is free. Each write to address 0x31 stores the next byte, at buffer index 0 upward, readable on `usb_in_rdata`. Writes beyond 64 bytes are ignored.
- R7: A write to address 0x33 commits the packet. One cycle later, `in_pkt_rdy` is high, `irq_buf` is low, and `in_pkt_len` equals the smallest of the written value, 64, and the wLength bytes still owed.
- R8: On `usb_in_ack`, if the committed length was below 64 or no bytes are still owed, `status_ok` pulses for one cycle. Otherwise the buffer becomes free again and `irq_buf` rises.
- R9: In the host-to-device direction, the bytes given with `usb_out_we` fill the buffer from index 0. After `usb_out_end`, `irq_buf` is high, a read of address 0x33 returns the clipped `usb_out_cnt`, and reads of address 0x31 return the packet bytes in order.
- R10: A write to address 0x33 in the host-to-device direction releases the buffer. `status_ok` pulses if the packet was shorter than 64 or no bytes are still owed; otherwise the block waits for the next packet with `irq_buf` low.
- R11: After reset, `irq_setup`, `irq_buf`, `ep0_stall`, `in_pkt_rdy`, `status_ok` and `reg_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| usb_setup_vld | input | 1 | Setup packet delivered this cycle |
| usb_setup_pkt | input | 64 | Setup packet, byte 0 in bits 7:0 |
| usb_in_ack | input | 1 | Host has taken the committed IN packet |
| usb_in_raddr | input | 6 | Buffer index read by the USB engine |
| usb_in_rdata | output | 8 | Buffer byte at `usb_in_raddr` |
| in_pkt_rdy | output | 1 | IN packet committed and waiting |
| in_pkt_len | output | 7 | Length of the committed IN packet |
| usb_out_we | input | 1 | OUT data byte strobe |
| usb_out_data | input | 8 | OUT data byte |
| usb_out_end | input | 1 | OUT packet complete |
| usb_out_cnt | input | 7 | Byte count of the finished OUT packet |
| reg_wr | input | 1 | Master register write strobe |
| reg_rd | input | 1 | Master register read strobe |
| reg_addr | input | 8 | Register address (0x31 data, 0x32 setup, 0x33 count) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data, valid one cycle after `reg_rd` |
| irq_setup | output | 1 | Setup packet waiting for the master |
| irq_buf | output | 1 | Endpoint-0 buffer needs the master |
| ep0_stall | output | 1 | Endpoint stalled |
| status_ok | output | 1 | One-cycle pulse: status stage completed |

## Verification
The assertions assume the following about the inputs:
- A setup packet, a register strobe and a USB data strobe never fall in the same cycle.
- `usb_in_ack` comes only while a packet is committed.
- `usb_out_end` comes only while the block is waiting for host data.
- `reg_rd` and `reg_wr` are never high together.

The bench keeps within these rules because every task drives a single one-cycle strobe at a falling edge and returns only after the next rising edge. Each scenario also follows the legal order of setup, fill, commit and acknowledge, or setup, host data, read and release.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_IN_FILL,
        ST_IN_BUSY,
        ST_OUT_WAIT,
        ST_OUT_FULL,
        ST_DONE,
        ST_STALLED
    } ep0_state_t;

endpackage

// File: rtl/ctl_setup_regs.sv
module ctl_setup_regs #(
    parameter int SETUP_BYTES = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       setup_vld,
    input  logic [8*SETUP_BYTES-1:0]   setup_pkt,
    input  logic                       rd_setup,
    output logic                       irq_setup,
    output logic [7:0]                 rd_byte
);
    localparam int PW = $clog2(SETUP_BYTES + 1);
    localparam int IW = $clog2(SETUP_BYTES);
    localparam logic [PW-1:0] PTR_END = PW'(SETUP_BYTES);

    logic [7:0]    bytes_q [SETUP_BYTES];
    logic [PW-1:0] ptr_q;
    logic          irq_q;

    always_ff @(posedge clk) begin
        if (setup_vld) begin
            for (int i = 0; i < SETUP_BYTES; i++) begin
                bytes_q[i] <= setup_pkt[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= '0;
            irq_q <= 1'b0;
        end else if (setup_vld) begin
            ptr_q <= '0;
            irq_q <= 1'b1;
        end else if (rd_setup) begin
            irq_q <= 1'b0;
            if (ptr_q != PTR_END) begin
                ptr_q <= ptr_q + 1'b1;
            end
        end
    end

    always_comb begin
        irq_setup = irq_q;
        rd_byte   = (ptr_q == PTR_END) ? 8'h00 : bytes_q[ptr_q[IW-1:0]];
    end

    // R1: a fresh setup raises the interrupt
    a_r1_setup_irq: assert property (@(posedge clk) disable iff (!rst_n)
        setup_vld |=> irq_setup);

    // R4: a fresh setup rewinds the read pointer
    a_r4_ptr_rewind: assert property (@(posedge clk) disable iff (!rst_n)
        setup_vld |=> (ptr_q == '0));

    // R2: the pointer never runs past the packet
    a_r2_ptr_bound: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= PTR_END);

    // R2: a read without a new setup advances by exactly one until the end
    a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_setup && !setup_vld && ptr_q != PTR_END) |=> (ptr_q == $past(ptr_q) + 1'b1));

endmodule

// File: rtl/ctl_ep0_buf.sv
module ctl_ep0_buf #(
    parameter int DEPTH = 64,
    parameter int DW    = 8
) (
    input  logic                     clk,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] waddr,
    input  logic [DW-1:0]            wdata,
    input  logic [$clog2(DEPTH)-1:0] raddr_a,
    output logic [DW-1:0]            rdata_a,
    input  logic [$clog2(DEPTH)-1:0] raddr_b,
    output logic [DW-1:0]            rdata_b
);
    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a = mem_q[raddr_a];
        rdata_b = mem_q[raddr_b];
    end

endmodule

// File: rtl/ctl_ep0_fsm.sv
module ctl_ep0_fsm
    import ctl_ep_pkg::*;
#(
    parameter int MAX_PKT = 64,
    localparam int AW = $clog2(MAX_PKT),
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          setup_vld,
    input  logic          setup_dir_in,
    input  logic [15:0]   setup_wlen,
    input  logic          wr_data,
    input  logic          wr_count,
    input  logic          wr_stall,
    input  logic          rd_data,
    input  logic [7:0]    wdata,
    input  logic          usb_in_ack,
    input  logic          usb_out_we,
    input  logic [7:0]    usb_out_data,
    input  logic          usb_out_end,
    input  logic [CW-1:0] usb_out_cnt,
    output logic          buf_we,
    output logic [AW-1:0] buf_waddr,
    output logic [7:0]    buf_wdata,
    output logic [AW-1:0] mst_raddr,
    output logic [CW-1:0] pkt_cnt,
    output logic          irq_buf,
    output logic          ep0_stall,
    output logic          in_pkt_rdy,
    output logic [CW-1:0] in_pkt_len,
    output logic          status_ok
);
    localparam logic [CW-1:0] FULL = CW'(MAX_PKT);

    ep0_state_t    state_q, state_d, setup_target;
    logic [CW-1:0] wptr_q;
    logic [AW-1:0] rptr_q;
    logic [CW-1:0] cnt_q;
    logic [15:0]   rem_q;
    logic [15:0]   in_clip, out_clip;
    logic          last_pkt, wptr_room;

    function automatic logic [15:0] clip_len(input logic [15:0] req, input logic [15:0] left);
        logic [15:0] m;
        m = (req > 16'(MAX_PKT)) ? 16'(MAX_PKT) : req;
        return (m > left) ? left : m;
    endfunction

    always_comb begin
        in_clip   = clip_len(16'(wdata), rem_q);
        out_clip  = clip_len(16'(usb_out_cnt), rem_q);
        last_pkt  = (cnt_q < FULL) || (rem_q == 16'd0);
        wptr_room = (wptr_q < FULL);
        if (setup_wlen == 16'd0) begin
            setup_target = ST_DONE;
        end else if (setup_dir_in) begin
            setup_target = ST_IN_FILL;
        end else begin
            setup_target = ST_OUT_WAIT;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE: state_d = ST_IDLE;
            ST_IN_FILL:  if (wr_count)    state_d = ST_IN_BUSY;
            ST_IN_BUSY:  if (usb_in_ack)  state_d = last_pkt ? ST_DONE : ST_IN_FILL;
            ST_OUT_WAIT: if (usb_out_end) state_d = ST_OUT_FULL;
            ST_OUT_FULL: if (wr_count)    state_d = last_pkt ? ST_DONE : ST_OUT_WAIT;
            ST_STALLED:  state_d = ST_STALLED;
            default:     state_d = ST_IDLE;
        endcase
        if (wr_stall)  state_d = ST_STALLED;
        if (setup_vld) state_d = setup_target;
    end

    // data-phase counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rem_q  <= '0;
        end else if (setup_vld) begin
            wptr_q <= '0;
            rptr_q <= '0;
            cnt_q  <= '0;
            rem_q  <= setup_wlen;
        end else begin
            unique case (state_q)
                ST_IN_FILL: begin
                    if (wr_data && wptr_room) wptr_q <= wptr_q + 1'b1;
                    if (wr_count) begin
                        cnt_q <= CW'(in_clip);
                        rem_q <= rem_q - in_clip;
                    end
                end
                ST_IN_BUSY: begin
                    if (usb_in_ack) wptr_q <= '0;
                end
                ST_OUT_WAIT: begin
                    if (usb_out_we && wptr_room) wptr_q <= wptr_q + 1'b1;
                    if (usb_out_end) begin
                        cnt_q  <= CW'(out_clip);
                        rem_q  <= rem_q - out_clip;
                        wptr_q <= '0;
                        rptr_q <= '0;
                    end
                end
                ST_OUT_FULL: begin
                    if (rd_data) rptr_q <= rptr_q + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        buf_we     = wptr_room && (((state_q == ST_IN_FILL) && wr_data) ||
                                   ((state_q == ST_OUT_WAIT) && usb_out_we));
        buf_waddr  = wptr_q[AW-1:0];
        buf_wdata  = (state_q == ST_OUT_WAIT) ? usb_out_data : wdata;
        mst_raddr  = rptr_q;
        pkt_cnt    = cnt_q;
        irq_buf    = (state_q == ST_IN_FILL) || (state_q == ST_OUT_FULL);
        ep0_stall  = (state_q == ST_STALLED);
        in_pkt_rdy = (state_q == ST_IN_BUSY);
        in_pkt_len = cnt_q;
        status_ok  = (state_q == ST_DONE);
    end

    // checker state: bytes handed to the host against the request length
    logic [16:0] sent_chk;
    logic [15:0] wlen_chk;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sent_chk <= '0;
            wlen_chk <= '0;
        end else if (setup_vld) begin
            sent_chk <= '0;
            wlen_chk <= setup_wlen;
        end else if (usb_in_ack && in_pkt_rdy) begin
            sent_chk <= sent_chk + 17'(in_pkt_len);
        end
    end

    // R7: total IN data never exceeds wLength
    a_r7_total_wlen: assert property (@(posedge clk) disable iff (!rst_n)
        sent_chk <= {1'b0, wlen_chk});

    // R7: a committed packet never exceeds the buffer
    a_r7_len_limit: assert property (@(posedge clk) disable iff (!rst_n)
        in_pkt_rdy |-> (in_pkt_len <= FULL));

    // R3: a non-zero write to the setup register stalls
    a_r3_stall_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stall && !setup_vld) |=> (ep0_stall && !irq_buf && !in_pkt_rdy));

    // R5: zero wLength completes the status stage at once
    a_r5_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_vld && setup_wlen == 16'd0) |=> status_ok);

    // R8: status completion is a single-cycle pulse
    a_r8_status_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (status_ok && !setup_vld) |=> !status_ok);

endmodule

// File: rtl/ctl_ep_handler.sv
module ctl_ep_handler #(
    parameter int MAX_PKT     = 64,
    parameter int SETUP_BYTES = 8,
    parameter logic [7:0] ADDR_DATA  = 8'h31,
    parameter logic [7:0] ADDR_SETUP = 8'h32,
    parameter logic [7:0] ADDR_COUNT = 8'h33,
    localparam int AW = $clog2(MAX_PKT),
    localparam int CW = $clog2(MAX_PKT + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     usb_setup_vld,
    input  logic [8*SETUP_BYTES-1:0] usb_setup_pkt,
    input  logic                     usb_in_ack,
    input  logic [AW-1:0]            usb_in_raddr,
    output logic [7:0]               usb_in_rdata,
    output logic                     in_pkt_rdy,
    output logic [CW-1:0]            in_pkt_len,
    input  logic                     usb_out_we,
    input  logic [7:0]               usb_out_data,
    input  logic                     usb_out_end,
    input  logic [CW-1:0]            usb_out_cnt,
    input  logic                     reg_wr,
    input  logic                     reg_rd,
    input  logic [7:0]               reg_addr,
    input  logic [7:0]               reg_wdata,
    output logic [7:0]               reg_rdata,
    output logic                     irq_setup,
    output logic                     irq_buf,
    output logic                     ep0_stall,
    output logic                     status_ok
);
    logic          rd_setup, rd_data, wr_data, wr_count, wr_stall;
    logic [7:0]    setup_byte, mst_rdata, buf_wdata;
    logic          buf_we;
    logic [AW-1:0] buf_waddr, mst_raddr;
    logic [CW-1:0] pkt_cnt;
    logic [15:0]   setup_wlen;

    always_comb begin
        rd_setup   = reg_rd && (reg_addr == ADDR_SETUP);
        rd_data    = reg_rd && (reg_addr == ADDR_DATA);
        wr_data    = reg_wr && (reg_addr == ADDR_DATA);
        wr_count   = reg_wr && (reg_addr == ADDR_COUNT);
        wr_stall   = reg_wr && (reg_addr == ADDR_SETUP) && (reg_wdata != 8'h00);
        setup_wlen = {usb_setup_pkt[63:56], usb_setup_pkt[55:48]};
    end

    ctl_setup_regs #(.SETUP_BYTES(SETUP_BYTES)) setup_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .setup_vld (usb_setup_vld),
        .setup_pkt (usb_setup_pkt),
        .rd_setup  (rd_setup),
        .irq_setup (irq_setup),
        .rd_byte   (setup_byte)
    );

    ctl_ep0_fsm #(.MAX_PKT(MAX_PKT)) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .setup_vld    (usb_setup_vld),
        .setup_dir_in (usb_setup_pkt[7]),
        .setup_wlen   (setup_wlen),
        .wr_data      (wr_data),
        .wr_count     (wr_count),
        .wr_stall     (wr_stall),
        .rd_data      (rd_data),
        .wdata        (reg_wdata),
        .usb_in_ack   (usb_in_ack),
        .usb_out_we   (usb_out_we),
        .usb_out_data (usb_out_data),
        .usb_out_end  (usb_out_end),
        .usb_out_cnt  (usb_out_cnt),
        .buf_we       (buf_we),
        .buf_waddr    (buf_waddr),
        .buf_wdata    (buf_wdata),
        .mst_raddr    (mst_raddr),
        .pkt_cnt      (pkt_cnt),
        .irq_buf      (irq_buf),
        .ep0_stall    (ep0_stall),
        .in_pkt_rdy   (in_pkt_rdy),
        .in_pkt_len   (in_pkt_len),
        .status_ok    (status_ok)
    );

    ctl_ep0_buf #(.DEPTH(MAX_PKT), .DW(8)) buf_i (
        .clk     (clk),
        .we      (buf_we),
        .waddr   (buf_waddr),
        .wdata   (buf_wdata),
        .raddr_a (usb_in_raddr),
        .rdata_a (usb_in_rdata),
        .raddr_b (mst_raddr),
        .rdata_b (mst_rdata)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            reg_rdata <= 8'h00;
        end else if (reg_rd) begin
            if (reg_addr == ADDR_SETUP)      reg_rdata <= setup_byte;
            else if (reg_addr == ADDR_DATA)  reg_rdata <= mst_rdata;
            else if (reg_addr == ADDR_COUNT) reg_rdata <= 8'(pkt_cnt);
            else                             reg_rdata <= 8'h00;
        end
    end

    // R1: the setup interrupt drops on the first read of the setup register
    a_r1_irq_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_setup && !usb_setup_vld) |=> !irq_setup);

    // R4: a new setup lifts the stall
    a_r4_stall_lift: assert property (@(posedge clk) disable iff (!rst_n)
        usb_setup_vld |=> !ep0_stall);

endmodule

// File: tb/ctl_ep_handler_tb_top.sv
`timescale 1ns/1ps
module ctl_ep_handler_tb_top;
    localparam logic [7:0] A_DATA  = 8'h31;
    localparam logic [7:0] A_SETUP = 8'h32;
    localparam logic [7:0] A_COUNT = 8'h33;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        usb_setup_vld = 1'b0;
    logic [63:0] usb_setup_pkt = '0;
    logic        usb_in_ack = 1'b0;
    logic [5:0]  usb_in_raddr = '0;
    logic [7:0]  usb_in_rdata;
    logic        in_pkt_rdy;
    logic [6:0]  in_pkt_len;
    logic        usb_out_we = 1'b0;
    logic [7:0]  usb_out_data = '0;
    logic        usb_out_end = 1'b0;
    logic [6:0]  usb_out_cnt = '0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic        irq_setup, irq_buf, ep0_stall, status_ok;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    ctl_ep_handler dut_i (
        .clk(clk), .rst_n(rst_n),
        .usb_setup_vld(usb_setup_vld), .usb_setup_pkt(usb_setup_pkt),
        .usb_in_ack(usb_in_ack), .usb_in_raddr(usb_in_raddr), .usb_in_rdata(usb_in_rdata),
        .in_pkt_rdy(in_pkt_rdy), .in_pkt_len(in_pkt_len),
        .usb_out_we(usb_out_we), .usb_out_data(usb_out_data),
        .usb_out_end(usb_out_end), .usb_out_cnt(usb_out_cnt),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_setup(irq_setup), .irq_buf(irq_buf),
        .ep0_stall(ep0_stall), .status_ok(status_ok)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_setup(input logic [63:0] p);
        @(negedge clk); usb_setup_vld = 1'b1; usb_setup_pkt = p;
        @(negedge clk); usb_setup_vld = 1'b0;
    endtask

    task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        @(negedge clk); reg_rd = 1'b0; d = reg_rdata;
    endtask

    task automatic host_ack();
        @(negedge clk); usb_in_ack = 1'b1;
        @(negedge clk); usb_in_ack = 1'b0;
    endtask

    task automatic host_byte(input logic [7:0] d);
        @(negedge clk); usb_out_we = 1'b1; usb_out_data = d;
        @(negedge clk); usb_out_we = 1'b0;
    endtask

    task automatic host_end(input logic [6:0] c);
        @(negedge clk); usb_out_end = 1'b1; usb_out_cnt = c;
        @(negedge clk); usb_out_end = 1'b0;
    endtask

    task automatic peek_in(input logic [5:0] a, output logic [7:0] d);
        usb_in_raddr = a; #1; d = usb_in_rdata;
    endtask

    task automatic t_reset();
        check("R11 irq_setup", 32'(irq_setup), 0);
        check("R11 irq_buf", 32'(irq_buf), 0);
        check("R11 ep0_stall", 32'(ep0_stall), 0);
        check("R11 in_pkt_rdy", 32'(in_pkt_rdy), 0);
        check("R11 status_ok", 32'(status_ok), 0);
        check("R11 reg_rdata", 32'(reg_rdata), 0);
    endtask

    task automatic t_setup_read();
        logic [7:0] d;
        send_setup(64'h0807_0605_0403_02C1);
        check("R1 irq_setup raised", 32'(irq_setup), 1);
        for (int i = 0; i < 8; i++) begin
            reg_read(A_SETUP, d);
            check("R2 setup byte order", 32'(d), 32'(i == 0 ? 8'hC1 : 8'(i + 1)));
            if (i == 0) check("R1 irq_setup cleared by read", 32'(irq_setup), 0);
        end
        reg_read(A_SETUP, d);
        check("R2 read past end", 32'(d), 0);
    endtask

    task automatic t_stall();
        logic [7:0] d;
        send_setup(64'h000A_0000_0100_0680);
        for (int i = 0; i < 3; i++) reg_read(A_SETUP, d);
        reg_write(A_SETUP, 8'h00);
        check("R3 zero write no stall", 32'(ep0_stall), 0);
        check("R3 zero write keeps buffer irq", 32'(irq_buf), 1);
        reg_write(A_SETUP, 8'h05);
        check("R3 stall asserted", 32'(ep0_stall), 1);
        check("R3 buffer irq dropped", 32'(irq_buf), 0);
        send_setup(64'h0000_0000_0000_0921);
        check("R4 stall cleared", 32'(ep0_stall), 0);
        check("R5 zero wLength status", 32'(status_ok), 1);
        reg_read(A_SETUP, d);
        check("R4 pointer rewound", 32'(d), 32'h21);
        check("R5 status pulse ended", 32'(status_ok), 0);
    endtask

    task automatic t_in_transfer();
        logic [7:0] d;
        send_setup(64'h0064_0000_0000_0080);
        check("R6 buffer irq on IN", 32'(irq_buf), 1);
        for (int i = 0; i < 66; i++) reg_write(A_DATA, 8'(8'h10 + i));
        peek_in(6'd0, d);  check("R6 first byte kept", 32'(d), 32'h10);
        peek_in(6'd63, d); check("R6 last byte, extras ignored", 32'(d), 32'h4F);
        reg_write(A_COUNT, 8'd64);
        check("R7 packet ready", 32'(in_pkt_rdy), 1);
        check("R7 length full", 32'(in_pkt_len), 64);
        check("R7 buffer irq low", 32'(irq_buf), 0);
        host_ack();
        check("R8 no status on full packet", 32'(status_ok), 0);
        check("R8 buffer free again", 32'(irq_buf), 1);
        for (int i = 0; i < 40; i++) reg_write(A_DATA, 8'(8'hA0 + i));
        reg_write(A_COUNT, 8'd200);
        check("R7 length clipped to wLength", 32'(in_pkt_len), 36);
        peek_in(6'd35, d); check("R6 second packet byte", 32'(d), 32'hC3);
        host_ack();
        check("R8 status after final packet", 32'(status_ok), 1);
        @(negedge clk);
        check("R8 idle after status", 32'(irq_buf), 0);
    endtask

    task automatic t_zlp();
        send_setup(64'h0080_0000_0000_0080);
        for (int i = 0; i < 64; i++) reg_write(A_DATA, 8'(i));
        reg_write(A_COUNT, 8'd64);
        host_ack();
        check("R8 full packet continues", 32'(irq_buf), 1);
        reg_write(A_COUNT, 8'd0);
        check("R7 zero-length ready", 32'(in_pkt_rdy), 1);
        check("R7 zero-length length", 32'(in_pkt_len), 0);
        host_ack();
        check("R8 zero-length ends data phase", 32'(status_ok), 1);
    endtask

    task automatic t_out();
        logic [7:0] d;
        send_setup(64'h0046_0000_0000_0001);
        check("R9 no irq before host data", 32'(irq_buf), 0);
        for (int i = 0; i < 64; i++) host_byte(8'(8'h30 + i));
        host_end(7'd64);
        check("R9 buffer irq on OUT packet", 32'(irq_buf), 1);
        reg_read(A_COUNT, d); check("R9 OUT count", 32'(d), 64);
        reg_read(A_DATA, d);  check("R9 OUT byte 0", 32'(d), 32'h30);
        reg_read(A_DATA, d);  check("R9 OUT byte 1", 32'(d), 32'h31);
        reg_write(A_COUNT, 8'd0);
        check("R10 release waits for more", 32'(irq_buf), 0);
        check("R10 no status yet", 32'(status_ok), 0);
        for (int i = 0; i < 6; i++) host_byte(8'(8'h90 + i));
        host_end(7'd6);
        reg_read(A_COUNT, d); check("R9 short OUT count", 32'(d), 6);
        reg_read(A_DATA, d);  check("R9 short OUT byte 0", 32'(d), 32'h90);
        reg_write(A_COUNT, 8'd0);
        check("R10 status after short OUT", 32'(status_ok), 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_setup_read();
        t_stall();
        t_in_transfer();
        t_zlp();
        t_out();
        repeat (2) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    end

endmodule